// File: doc/BRIEF.md
# Channel-Range Readout Strobe Sequencer

This block turns one packed transmit command into a run of readout strobes, one per channel. The command carries a first and a last channel number. The block walks every channel from the first to the last, one per strobe. With each strobe it drives a 7-bit channel address. Strobes are spaced a fixed, parameterised number of clocks apart. While a sweep is in progress, a busy output tells the command source to hold off. A command whose last channel is below its first is rejected with a one-cycle error pulse.

The same block also holds the select logic that sits on each converter board. That logic compares the upper four address bits with the board's own number. On a match it works in one of two ways:

- **Bulk mode:** it pops one word of the board's output queue.
- **Single-converter mode:** it enables the one converter of eight that the low three address bits name.

A sweep can therefore cross board boundaries. Each board answers only the addresses that fall in its own group of eight.

Top module: `chan_sweep_top`

## Requirements
- R1: A command is taken only in a cycle where `cmd_valid` is high, `cmd_word[23:12]` equals 0x00F and `busy` is low. Any other command has no effect: no strobe and no error pulse.
- R2: The first channel is `cmd_word[5:0]` and the last channel is `cmd_word[11:6]`. An accepted command with last >= first gives exactly last - first + 1 strobes. The addresses step upward by one from first to last. For example, 0x00F246 gives addresses 6, 7, 8, 9 and 0x00F041 gives address 1 only.
- R3: The first strobe is high in the cycle right after acceptance. Each following strobe comes GAP clocks after the one before it. Each strobe is high for a single cycle.
- R4: `chan_addr` is {0, channel}: bit 6 is always 0 while `strobe` is high.
- R5: `busy` goes high in the cycle after acceptance when more than one strobe remains. It stays high until the cycle in which the last strobe is presented, and it is low in that cycle.
- R6: An accepted command with last < first gives no strobe and leaves `busy` low. Instead, `cmd_err` is high for exactly the one cycle after acceptance.
- R7: A strobe addresses this board when `chan_addr[6:3]` equals `board_id`. The select outputs respond one cycle after that strobe, for one cycle.
- R8: With `single_mode` = 0 at the strobe, a matching strobe gives a `fifo_pop` pulse whatever `chan_addr[2:0]` holds. In that case `conv_en` stays low and `conv_sel` stays 0.
- R9: With `single_mode` = 1 at the strobe, a matching strobe gives a `conv_en` pulse with `conv_sel` = 1 << `chan_addr[2:0]`, and `fifo_pop` stays low. `conv_sel` is 0 whenever `conv_en` is low.
- R10: A strobe whose upper address bits do not match `board_id` leaves `fifo_pop`, `conv_en` and `conv_sel` all low.
- R11: After a synchronous reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_word | input | 24 | Tag [23:12], last channel [11:6], first channel [5:0] |
| board_id | input | 4 | Number of this board, compared with address bits 6..3 |
| single_mode | input | 1 | 0: pop queue word per strobe; 1: select one converter |
| strobe | output | 1 | Readout strobe, one cycle per channel |
| chan_addr | output | 7 | Channel address, valid while strobe is high |
| busy | output | 1 | Sweep in progress; new commands ignored |
| cmd_err | output | 1 | One-cycle pulse for a reversed range |
| fifo_pop | output | 1 | Bulk-mode read of one queue word |
| conv_en | output | 1 | Single-converter read enable |
| conv_sel | output | 8 | One-hot converter select |

## Verification
The assertions assume that `single_mode` and `board_id` are steady around each strobe. They also assume that `cmd_word` is meaningful only while `cmd_valid` is high. The stimulus sets mode and board number before each command and holds them until the sweep and its trailing select cycle are over. The only command offered during a sweep is a deliberate one, used to show that it is ignored. Because the checks on select outputs compare against the strobe of the previous cycle, the stimulus never changes the mode in the middle of a sweep.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  localparam logic [11:0] CMD_TAG = 12'h00F;

  typedef struct packed {
    logic [11:0] tag;
    logic [5:0]  last;
    logic [5:0]  first;
  } sweep_cmd_t;
endpackage

// File: rtl/sweep_cmd_dec.sv
module sweep_cmd_dec
  import sweep_pkg::*;
#(
  parameter int CH_W = 6
) (
  input  logic [23:0]     word,
  output logic            tag_ok,
  output logic            reversed,
  output logic [CH_W-1:0] first,
  output logic [CH_W-1:0] last
);
  sweep_cmd_t c;

  always_comb begin
    c        = sweep_cmd_t'(word);
    tag_ok   = (c.tag == CMD_TAG);
    first    = CH_W'(c.first);
    last     = CH_W'(c.last);
    reversed = (last < first);
  end
endmodule

// File: rtl/sweep_strobe_gen.sv
module sweep_strobe_gen #(
  parameter int CH_W = 6,
  parameter int GAP  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            bad,
  input  logic [CH_W-1:0] first,
  input  logic [CH_W-1:0] last,
  output logic            busy,
  output logic            strobe,
  output logic            err,
  output logic [CH_W:0]   addr
);
  localparam int CNT_W = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(GAP - 1);

  logic [CH_W-1:0] cur;
  logic [CH_W-1:0] stop;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      strobe <= 1'b0;
      err    <= 1'b0;
      addr   <= '0;
      cur    <= '0;
      stop   <= '0;
      cnt    <= '0;
    end else begin
      strobe <= 1'b0;
      err    <= 1'b0;
      if (!busy) begin
        if (go) begin
          if (bad) begin
            err <= 1'b1;
          end else begin
            strobe <= 1'b1;
            addr   <= {1'b0, first};
            stop   <= last;
            cur    <= first + 1'b1;
            cnt    <= RELOAD;
            busy   <= (first != last);
          end
        end
      end else if (cnt == '0) begin
        strobe <= 1'b1;
        addr   <= {1'b0, cur};
        if (cur == stop) begin
          busy <= 1'b0;
        end else begin
          cur <= cur + 1'b1;
          cnt <= RELOAD;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sweep_board_sel.sv
module sweep_board_sel #(
  parameter int ADDR_W = 7,
  parameter int SUB_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     strobe,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [ADDR_W-SUB_W-1:0]  board_id,
  input  logic                     single_mode,
  output logic                     fifo_pop,
  output logic                     conv_en,
  output logic [(1<<SUB_W)-1:0]    conv_sel
);
  localparam int NCONV = 1 << SUB_W;

  logic             hit;
  logic [NCONV-1:0] dec;

  assign hit = strobe && (addr[ADDR_W-1:SUB_W] == board_id);

  for (genvar g = 0; g < NCONV; g++) begin : g_dec
    assign dec[g] = (addr[SUB_W-1:0] == SUB_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_pop <= 1'b0;
      conv_en  <= 1'b0;
      conv_sel <= '0;
    end else begin
      fifo_pop <= hit && !single_mode;
      conv_en  <= hit && single_mode;
      conv_sel <= (hit && single_mode) ? dec : '0;
    end
  end
endmodule

// File: rtl/chan_sweep_top.sv
module chan_sweep_top #(
  parameter int CH_W  = 6,
  parameter int SUB_W = 3,
  parameter int GAP   = 4,
  localparam int ADDR_W = CH_W + 1,
  localparam int BID_W  = ADDR_W - SUB_W,
  localparam int NCONV  = 1 << SUB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [23:0]       cmd_word,
  input  logic [BID_W-1:0]  board_id,
  input  logic              single_mode,
  output logic              strobe,
  output logic [ADDR_W-1:0] chan_addr,
  output logic              busy,
  output logic              cmd_err,
  output logic              fifo_pop,
  output logic              conv_en,
  output logic [NCONV-1:0]  conv_sel
);
  logic            tag_ok;
  logic            reversed;
  logic [CH_W-1:0] first;
  logic [CH_W-1:0] last;
  logic            go;

  sweep_cmd_dec #(.CH_W(CH_W)) u_dec (
    .word     (cmd_word),
    .tag_ok   (tag_ok),
    .reversed (reversed),
    .first    (first),
    .last     (last)
  );

  assign go = cmd_valid && tag_ok;

  sweep_strobe_gen #(.CH_W(CH_W), .GAP(GAP)) u_gen (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .bad    (reversed),
    .first  (first),
    .last   (last),
    .busy   (busy),
    .strobe (strobe),
    .err    (cmd_err),
    .addr   (chan_addr)
  );

  sweep_board_sel #(.ADDR_W(ADDR_W), .SUB_W(SUB_W)) u_sel (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .addr        (chan_addr),
    .board_id    (board_id),
    .single_mode (single_mode),
    .fifo_pop    (fifo_pop),
    .conv_en     (conv_en),
    .conv_sel    (conv_sel)
  );
endmodule

// File: rtl/sweep_chk.sv
module sweep_chk #(
  parameter int ADDR_W = 7,
  parameter int SUB_W  = 3,
  parameter int GAP    = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    strobe,
  input logic [ADDR_W-1:0]       chan_addr,
  input logic                    busy,
  input logic                    cmd_err,
  input logic                    single_mode,
  input logic [ADDR_W-SUB_W-1:0] board_id,
  input logic                    fifo_pop,
  input logic                    conv_en,
  input logic [(1<<SUB_W)-1:0]   conv_sel
);
  localparam bit WIDE_GAP = (GAP > 1);

  p_addr_msb_r4: assert property (@(posedge clk) disable iff (rst)
    strobe |-> !chan_addr[ADDR_W-1]);

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe && WIDE_GAP) |=> !strobe);

  p_err_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> (!busy && !strobe));

  p_err_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_err |=> !cmd_err);

  p_busy_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> strobe);

  p_pop_after_hit_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> ($past(strobe) &&
                  $past(chan_addr[ADDR_W-1:SUB_W]) == $past(board_id)));

  p_pop_mode_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> ($past(!single_mode) && !conv_en));

  p_sel_count_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(conv_sel) == (conv_en ? 1 : 0));

  p_sel_addr_r9: assert property (@(posedge clk) disable iff (rst)
    conv_en |-> ($past(single_mode) && $past(strobe) &&
                 conv_sel == ((1 << SUB_W)'(1) << $past(chan_addr[SUB_W-1:0]))));

  p_no_stray_r10: assert property (@(posedge clk) disable iff (rst)
    (strobe && chan_addr[ADDR_W-1:SUB_W] != board_id) |=> (!fifo_pop && !conv_en));
endmodule

bind chan_sweep_top sweep_chk #(.ADDR_W(ADDR_W), .SUB_W(SUB_W), .GAP(GAP)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .strobe      (strobe),
  .chan_addr   (chan_addr),
  .busy        (busy),
  .cmd_err     (cmd_err),
  .single_mode (single_mode),
  .board_id    (board_id),
  .fifo_pop    (fifo_pop),
  .conv_en     (conv_en),
  .conv_sel    (conv_sel)
);

// File: tb/tb_chan_sweep_top.sv
module tb_chan_sweep_top;
  localparam int GAP = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [23:0] cmd_word = '0;
  logic [3:0]  board_id = '0;
  logic        single_mode = 1'b0;
  logic        strobe;
  logic [6:0]  chan_addr;
  logic        busy;
  logic        cmd_err;
  logic        fifo_pop;
  logic        conv_en;
  logic [7:0]  conv_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  chan_sweep_top #(.GAP(GAP)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .board_id(board_id), .single_mode(single_mode), .strobe(strobe),
    .chan_addr(chan_addr), .busy(busy), .cmd_err(cmd_err),
    .fifo_pop(fifo_pop), .conv_en(conv_en), .conv_sel(conv_sel)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cmd %h)", rq, act, exp, cmd_word);
    end
  endtask

  task automatic run_cmd(input logic [23:0] w, input logic mode,
                         input logic [3:0] bid, input bit inj);
    int s, e, cnt, ncyc;
    bit tagok, exp_s, ps, hit, exp_b;
    logic [6:0] ea, pa;
    logic [7:0] esel;
    s = int'(w[5:0]);
    e = int'(w[11:6]);
    tagok = (w[23:12] == 12'h00F);
    cnt = (!tagok || e < s) ? 0 : e - s + 1;
    @(negedge clk);
    cmd_word = w; cmd_valid = 1'b1; single_mode = mode; board_id = bid;
    @(negedge clk);
    cmd_valid = 1'b0;
    ps = 1'b0; pa = '0;
    ncyc = cnt * GAP + 3;
    for (int i = 0; i < ncyc; i++) begin
      if (i > 0) @(negedge clk);
      exp_s = (i % GAP == 0) && (i / GAP < cnt);
      ea = 7'(s + i / GAP);
      chk(strobe == exp_s, "R2/R3 strobe", int'(strobe), int'(exp_s));
      if (exp_s && strobe) begin
        chk(chan_addr == ea, "R2 address", int'(chan_addr), int'(ea));
        chk(chan_addr[6] == 1'b0, "R4 bit6", int'(chan_addr[6]), 0);
      end
      exp_b = (cnt > 0) && (i < (cnt - 1) * GAP);
      chk(busy == exp_b, "R5 busy", int'(busy), int'(exp_b));
      chk(cmd_err == (i == 0 && tagok && e < s), "R6/R1 err", int'(cmd_err),
          int'(i == 0 && tagok && e < s));
      hit = ps && (pa[6:3] == bid);
      esel = (hit && mode) ? (8'b1 << pa[2:0]) : 8'h00;
      chk(fifo_pop == (hit && !mode), "R7/R8/R10 pop", int'(fifo_pop), int'(hit && !mode));
      chk(conv_en == (hit && mode), "R7/R9/R10 en", int'(conv_en), int'(hit && mode));
      chk(conv_sel == esel, "R9 sel", int'(conv_sel), int'(esel));
      ps = exp_s; pa = ea;
      if (inj && i == 1) begin cmd_word = 24'h00F000; cmd_valid = 1'b1; end
      if (inj && i == 2) begin cmd_valid = 1'b0; cmd_word = w; end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_word = 24'h00F1C0;
    @(negedge clk);
    // R11: outputs held low during reset even with a command present
    chk({strobe, busy, cmd_err, fifo_pop, conv_en, conv_sel, chan_addr} == '0,
        "R11 reset", int'(strobe), 0);
    cmd_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk({strobe, busy, cmd_err, fifo_pop, conv_en, conv_sel} == '0, "R11 idle", int'(busy), 0);

    // R2 R3 R5 R6 R7 R8 R9 R10: exhaustive small range sweep, two boards, both modes
    for (int m = 0; m < 2; m++)
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < 16; s++)
          for (int e = 0; e < 16; e++)
            run_cmd({12'h00F, 6'(e), 6'(s)}, 1'(m), 4'(b), 1'b0);

    // full range, board near the top of the address space
    run_cmd(24'h00FFC0, 1'b0, 4'd7, 1'b0);
    run_cmd(24'h00FFC0, 1'b1, 4'd7, 1'b0);
    run_cmd(24'h00F7CF, 1'b1, 4'd2, 1'b0);
    run_cmd(24'h00FFFF, 1'b1, 4'd7, 1'b0);
    // R10: boards 8..15 can never match, since bit 6 is 0
    run_cmd(24'h00FFC0, 1'b0, 4'd9, 1'b0);
    // R1: bad tag ignored
    run_cmd(24'h00E1C0, 1'b0, 4'd0, 1'b0);
    run_cmd(24'h01F1C0, 1'b1, 4'd0, 1'b0);
    run_cmd(24'h0000C0, 1'b0, 4'd0, 1'b0);
    // R1: command while busy ignored
    run_cmd(24'h00F246, 1'b0, 4'd0, 1'b1);
    run_cmd(24'h00F246, 1'b1, 4'd1, 1'b1);
    // R6: reversed range
    run_cmd(24'h00F047, 1'b0, 4'd0, 1'b0);
    // R1: cmd_valid low with a good word does nothing
    @(negedge clk); cmd_word = 24'h00F1C0;
    repeat (4) begin
      @(negedge clk);
      chk(!strobe && !busy && !cmd_err, "R1 no valid", int'(strobe), 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule